// File: doc/BRIEF.md
# Frame Statistics Counter Bank

This block keeps the per-port traffic statistics of an Ethernet MAC. Once per frame, the receive or transmit datapath presents an end-of-frame event. The event carries the frame length in octets, a direction bit, error flags (bad FCS, alignment, in-range length mismatch), a drop flag, PAUSE and VLAN indications and a destination class. The bank turns each event into increments of a fixed set of 64-bit counters. These cover good and errored frames, octet totals, destination class, size-class counters and a seven-bin length histogram. The upper edge of the histogram comes from a programmable maximum frame length.

The bank accepts one event per clock cycle with no back-pressure. The event is registered, classified in the next cycle, and all affected counters step together. Software reads each 64-bit counter as two 32-bit words through a one-cycle registered read port. A read of the upper word captures the matching lower word in a shadow register, so the pair forms one consistent snapshot even while traffic keeps counting. Counters clear on reset and roll over modulo 2^64.

Top module: `stat_bank`

## Requirements
- R1: After reset every counter reads 0, `rd_data` is 0, and the maximum frame length is 1536.
- R2: Counter k has its upper word at address 2k and its lower word at 2k+1. `rd_data` shows the addressed word on the cycle after `rd_en` and holds its value while `rd_en` is low. The indexes are:
  - 0 tx good
  - 1 rx good
  - 2 rx FCS error
  - 3 rx alignment error
  - 4 tx PAUSE
  - 5 rx PAUSE
  - 6 rx too long
  - 7 rx in-range length error
  - 8 tx VLAN
  - 9 rx VLAN
  - 10 tx octets
  - 11 rx octets
  - 12/13/14 rx unicast/multicast/broadcast
  - 15 tx error
  - 16/17/18 tx unicast/multicast/broadcast
  - 19 rx drop
  - 20 rx undersize
  - 21..27 rx histogram bins
  - 28 rx oversize
  - 29 rx jabber
  - 30 rx fragment
  - 31 rx error
- R3: A received frame that is not dropped is an error if it has a bad FCS, an alignment error, a length error, fewer than 64 octets, or more than the maximum length. An errored frame increments rx error, plus the FCS, alignment and in-range counters for the matching flags, plus too long when it exceeds the maximum. Any other frame increments rx good.
- R4: A good received frame increments one destination counter, chosen by `ev_dst` (0 unicast, 1 multicast, 2 broadcast, 3 none). It also increments rx VLAN when `ev_vlan` is set and rx PAUSE when `ev_pause` is set.
- R5: The octet counters add the frame length. Rx octets grows for every received frame that is not dropped, and tx octets for every transmitted frame.
- R6: A received frame from 64 octets up to the maximum length increments exactly one histogram bin. The bins are: 64 (21), 65–127 (22), 128–255 (23), 256–511 (24), 512–1023 (25), 1024–1518 (26), and 1519 to the maximum (27).
- R7: A received frame under 64 octets counts as undersize with a good FCS and as a fragment with a bad FCS. One over the maximum counts as oversize with a good FCS and as a jabber with a bad FCS.
- R8: Pulsing `maxlen_we` loads `maxlen_wdata` as the maximum frame length. Events presented later are classified against the new value.
- R9: A transmitted frame with `ev_fcs_bad` set increments tx error. Otherwise it increments tx good, one tx destination counter, and tx VLAN and tx PAUSE per their flags. On transmit, the alignment, length-error and drop flags have no effect.
- R10: A received frame with `ev_drop` set increments only rx drop.
- R11: A read of the upper word of counter k captures its lower word. The next lower-word read of the same counter returns the captured value and consumes it. A lower-word read with no pending capture for that counter returns the live value.
- R12: Events arriving every cycle are all counted, including in cycles that also carry a register read, and carries propagate across the 32-bit word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | End-of-frame event strobe |
| ev_tx | input | 1 | 1 = transmitted frame, 0 = received frame |
| ev_len | input | 16 | Frame length in octets |
| ev_fcs_bad | input | 1 | Bad FCS (on transmit: frame errored) |
| ev_align_bad | input | 1 | Alignment error (receive only) |
| ev_len_bad | input | 1 | In-range length field mismatch (receive only) |
| ev_drop | input | 1 | Received frame dropped (receive only) |
| ev_pause | input | 1 | Frame is a PAUSE control frame |
| ev_vlan | input | 1 | Frame carries a VLAN tag |
| ev_dst | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast, 3 none |
| maxlen_we | input | 1 | Load strobe for the maximum frame length |
| maxlen_wdata | input | 16 | New maximum frame length |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Word address (2k upper, 2k+1 lower) |
| rd_data | output | 32 | Registered read data |

## Verification
A counter update and a register read can fall in the same cycle, because events carry no handshake and reads may arrive at any time. The bench provokes this with long runs that present an event in every cycle and a random read in about half of them. One run pushes the transmit octet count past 2^32. After the traffic stops, every counter must equal the bench model, so that no increment is lost or doubled. A further directed sequence captures the upper word, sends more frames, and then requires the lower word to return the captured value rather than the live one.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

  localparam int NUM_CTR = 32;
  localparam int LEN_W   = 16;
  localparam int ADDR_W  = $clog2(2 * NUM_CTR);

  // counter indexes; the word address of counter k is 2k (upper) and 2k+1 (lower)
  localparam int C_TX_GOOD    = 0;
  localparam int C_RX_GOOD    = 1;
  localparam int C_RX_FCS     = 2;
  localparam int C_RX_ALIGN   = 3;
  localparam int C_TX_PAUSE   = 4;
  localparam int C_RX_PAUSE   = 5;
  localparam int C_RX_LONG    = 6;
  localparam int C_RX_INRANGE = 7;
  localparam int C_TX_VLAN    = 8;
  localparam int C_RX_VLAN    = 9;
  localparam int C_TX_OCT     = 10;
  localparam int C_RX_OCT     = 11;
  localparam int C_RX_UC      = 12;
  localparam int C_RX_MC      = 13;
  localparam int C_RX_BC      = 14;
  localparam int C_TX_ERR     = 15;
  localparam int C_TX_UC      = 16;
  localparam int C_TX_MC      = 17;
  localparam int C_TX_BC      = 18;
  localparam int C_RX_DROP    = 19;
  localparam int C_RX_UNDER   = 20;
  localparam int C_RX_B64     = 21;
  localparam int C_RX_B127    = 22;
  localparam int C_RX_B255    = 23;
  localparam int C_RX_B511    = 24;
  localparam int C_RX_B1023   = 25;
  localparam int C_RX_B1518   = 26;
  localparam int C_RX_BMAX    = 27;
  localparam int C_RX_OVER    = 28;
  localparam int C_RX_JAB     = 29;
  localparam int C_RX_FRAG    = 30;
  localparam int C_RX_ERR     = 31;

  // histogram edges in octets
  localparam logic [LEN_W-1:0] MIN_FRAME_LEN = LEN_W'(64);
  localparam logic [LEN_W-1:0] EDGE_127      = LEN_W'(127);
  localparam logic [LEN_W-1:0] EDGE_255      = LEN_W'(255);
  localparam logic [LEN_W-1:0] EDGE_511      = LEN_W'(511);
  localparam logic [LEN_W-1:0] EDGE_1023     = LEN_W'(1023);
  localparam logic [LEN_W-1:0] EDGE_1518     = LEN_W'(1518);

  typedef enum logic [1:0] {
    DST_UNI   = 2'd0,
    DST_MULTI = 2'd1,
    DST_BCAST = 2'd2,
    DST_NONE  = 2'd3
  } dst_e;

  typedef struct packed {
    logic             tx;
    logic [LEN_W-1:0] len;
    logic             fcs_bad;
    logic             align_bad;
    logic             len_bad;
    logic             drop;
    logic             pause;
    logic             vlan;
    dst_e             dst;
  } frame_ev_t;

endpackage

// File: rtl/stat_classify.sv
module stat_classify
  import stat_bank_pkg::*;
(
  input  logic               valid,
  input  frame_ev_t          ev,
  input  logic [LEN_W-1:0]   max_len,
  output logic [NUM_CTR-1:0] bump
);

  logic short_f;
  logic long_f;
  logic rx_bad;

  function automatic int size_bin(input logic [LEN_W-1:0] l);
    if (l == MIN_FRAME_LEN)   return C_RX_B64;
    else if (l <= EDGE_127)   return C_RX_B127;
    else if (l <= EDGE_255)   return C_RX_B255;
    else if (l <= EDGE_511)   return C_RX_B511;
    else if (l <= EDGE_1023)  return C_RX_B1023;
    else if (l <= EDGE_1518)  return C_RX_B1518;
    else                      return C_RX_BMAX;
  endfunction

  always_comb begin
    bump    = '0;
    short_f = (ev.len < MIN_FRAME_LEN);
    long_f  = (ev.len > max_len);
    rx_bad  = ev.fcs_bad | ev.align_bad | ev.len_bad | short_f | long_f;
    if (valid) begin
      if (ev.tx) begin
        bump[C_TX_OCT] = 1'b1;
        if (ev.fcs_bad) begin
          bump[C_TX_ERR] = 1'b1;
        end else begin
          bump[C_TX_GOOD]  = 1'b1;
          bump[C_TX_VLAN]  = ev.vlan;
          bump[C_TX_PAUSE] = ev.pause;
          case (ev.dst)
            DST_UNI:   bump[C_TX_UC] = 1'b1;
            DST_MULTI: bump[C_TX_MC] = 1'b1;
            DST_BCAST: bump[C_TX_BC] = 1'b1;
            default:   ;
          endcase
        end
      end else if (ev.drop) begin
        bump[C_RX_DROP] = 1'b1;
      end else begin
        bump[C_RX_OCT]     = 1'b1;
        bump[C_RX_FCS]     = ev.fcs_bad;
        bump[C_RX_ALIGN]   = ev.align_bad;
        bump[C_RX_INRANGE] = ev.len_bad;
        bump[C_RX_LONG]    = long_f;
        if (rx_bad) begin
          bump[C_RX_ERR] = 1'b1;
        end else begin
          bump[C_RX_GOOD]  = 1'b1;
          bump[C_RX_VLAN]  = ev.vlan;
          bump[C_RX_PAUSE] = ev.pause;
          case (ev.dst)
            DST_UNI:   bump[C_RX_UC] = 1'b1;
            DST_MULTI: bump[C_RX_MC] = 1'b1;
            DST_BCAST: bump[C_RX_BC] = 1'b1;
            default:   ;
          endcase
        end
        if (short_f)
          bump[ev.fcs_bad ? C_RX_FRAG : C_RX_UNDER] = 1'b1;
        else if (long_f)
          bump[ev.fcs_bad ? C_RX_JAB : C_RX_OVER] = 1'b1;
        else
          bump[size_bin(ev.len)] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/stat_ctr.sv
module stat_ctr
  import stat_bank_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter bit BY_LEN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic [LEN_W-1:0] len,
  output logic [CNT_W-1:0] value
);

  logic [CNT_W-1:0] step;

  generate
    if (BY_LEN) begin : g_len
      assign step = {{(CNT_W-LEN_W){1'b0}}, len};
    end else begin : g_one
      assign step = CNT_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (bump) value <= value + step;
  end

endmodule

// File: rtl/stat_rd.sv
module stat_rd
  import stat_bank_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_CTR-1:0][CNT_W-1:0] ctrs,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [CNT_W/2-1:0]            rd_data
);

  localparam int HALF  = CNT_W / 2;
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             want_lo;
  logic [HALF-1:0]  snap_lo;
  logic [IDX_W-1:0] snap_idx;
  logic             snap_live;

  assign idx     = rd_addr[ADDR_W-1:1];
  assign want_lo = rd_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      snap_lo   <= '0;
      snap_idx  <= '0;
      snap_live <= 1'b0;
    end else if (rd_en) begin
      if (!want_lo) begin
        rd_data   <= ctrs[idx][CNT_W-1:HALF];
        snap_lo   <= ctrs[idx][HALF-1:0];
        snap_idx  <= idx;
        snap_live <= 1'b1;
      end else if (snap_live && snap_idx == idx) begin
        rd_data   <= snap_lo;
        snap_live <= 1'b0;
      end else begin
        rd_data   <= ctrs[idx][HALF-1:0];
      end
    end
  end

endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int               CNT_W      = 64,
  parameter logic [LEN_W-1:0] MAXLEN_RST = 16'h0600
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic               ev_tx,
  input  logic [LEN_W-1:0]   ev_len,
  input  logic               ev_fcs_bad,
  input  logic               ev_align_bad,
  input  logic               ev_len_bad,
  input  logic               ev_drop,
  input  logic               ev_pause,
  input  logic               ev_vlan,
  input  logic [1:0]         ev_dst,
  input  logic               maxlen_we,
  input  logic [LEN_W-1:0]   maxlen_wdata,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [CNT_W/2-1:0] rd_data
);

  frame_ev_t                     ev_q;
  logic                          ev_v_q;
  logic [LEN_W-1:0]              max_len_q;
  logic [NUM_CTR-1:0]            bump;
  logic [NUM_CTR-1:0][CNT_W-1:0] ctr_val;

  // event capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_v_q <= 1'b0;
      ev_q   <= '0;
    end else begin
      ev_v_q <= ev_valid;
      if (ev_valid) begin
        ev_q.tx        <= ev_tx;
        ev_q.len       <= ev_len;
        ev_q.fcs_bad   <= ev_fcs_bad;
        ev_q.align_bad <= ev_align_bad;
        ev_q.len_bad   <= ev_len_bad;
        ev_q.drop      <= ev_drop;
        ev_q.pause     <= ev_pause;
        ev_q.vlan      <= ev_vlan;
        ev_q.dst       <= dst_e'(ev_dst);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            max_len_q <= MAXLEN_RST;
    else if (maxlen_we) max_len_q <= maxlen_wdata;
  end

  stat_classify u_cls (
    .valid   (ev_v_q),
    .ev      (ev_q),
    .max_len (max_len_q),
    .bump    (bump)
  );

  generate
    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      stat_ctr #(
        .CNT_W  (CNT_W),
        .BY_LEN ((i == C_TX_OCT) || (i == C_RX_OCT))
      ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .bump  (bump[i]),
        .len   (ev_q.len),
        .value (ctr_val[i])
      );
    end
  endgenerate

  stat_rd #(.CNT_W(CNT_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .ctrs    (ctr_val),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
  import stat_bank_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               ev_v_q,
  input logic               ev_tx_q,
  input logic [NUM_CTR-1:0] bump,
  input logic               maxlen_we,
  input logic [LEN_W-1:0]   maxlen_wdata,
  input logic [LEN_W-1:0]   max_len_q,
  input logic               rd_en,
  input logic [CNT_W/2-1:0] rd_data,
  input logic [CNT_W-1:0]   rx_good
);

  // R3: no counter moves without a captured event
  p_idle_no_bump_r3: assert property (@(posedge clk) disable iff (rst)
    !ev_v_q |-> (bump == '0));

  // R3: a received frame is good, errored or dropped, never two of these
  p_good_err_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bump[C_RX_GOOD], bump[C_RX_ERR], bump[C_RX_DROP]}));

  // R6: at most one size class per frame (undersize .. fragment are contiguous)
  p_one_size_class_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bump[C_RX_FRAG:C_RX_UNDER]));

  // R8: the length limit takes the written value
  p_maxlen_load_r8: assert property (@(posedge clk) disable iff (rst)
    maxlen_we |=> (max_len_q == $past(maxlen_wdata)));

  // R9: a transmitted frame never touches the rx good counter
  p_tx_not_rx_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_v_q && ev_tx_q) |-> !bump[C_RX_GOOD]);

  // R2: read data holds without a read
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R12: the good-frame counter steps by at most one per cycle
  p_good_step_r12: assert property (@(posedge clk) disable iff (rst)
    (rx_good == $past(rx_good)) || (rx_good == $past(rx_good) + CNT_W'(1)));

endmodule

bind stat_bank stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ev_v_q       (ev_v_q),
  .ev_tx_q      (ev_q.tx),
  .bump         (bump),
  .maxlen_we    (maxlen_we),
  .maxlen_wdata (maxlen_wdata),
  .max_len_q    (max_len_q),
  .rd_en        (rd_en),
  .rd_data      (rd_data),
  .rx_good      (ctr_val[stat_bank_pkg::C_RX_GOOD])
);

// File: tb/tb_stat_bank.sv
`timescale 1ns/1ps
module tb_stat_bank;
  import stat_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_valid = 0, ev_tx = 0, ev_fcs_bad = 0, ev_align_bad = 0;
  logic        ev_len_bad = 0, ev_drop = 0, ev_pause = 0, ev_vlan = 0;
  logic [15:0] ev_len = 0;
  logic [1:0]  ev_dst = 0;
  logic        maxlen_we = 0;
  logic [15:0] maxlen_wdata = 0;
  logic        rd_en = 0;
  logic [5:0]  rd_addr = 0;
  logic [31:0] rd_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [63:0] exp_c [NUM_CTR];
  int model_max = 1536;

  always #5 clk = ~clk;

  stat_bank dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_tx(ev_tx), .ev_len(ev_len),
    .ev_fcs_bad(ev_fcs_bad), .ev_align_bad(ev_align_bad), .ev_len_bad(ev_len_bad),
    .ev_drop(ev_drop), .ev_pause(ev_pause), .ev_vlan(ev_vlan), .ev_dst(ev_dst),
    .maxlen_we(maxlen_we), .maxlen_wdata(maxlen_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic string req_of(int k);
    if (k >= C_RX_B64 && k <= C_RX_BMAX) return "R6";
    if (k == C_RX_UNDER || k == C_RX_OVER || k == C_RX_JAB || k == C_RX_FRAG) return "R7";
    if (k == C_TX_OCT || k == C_RX_OCT) return "R5";
    if (k == C_RX_DROP) return "R10";
    if (k == C_TX_GOOD || k == C_TX_ERR || k == C_TX_VLAN || k == C_TX_PAUSE ||
        (k >= C_TX_UC && k <= C_TX_BC)) return "R9";
    if ((k >= C_RX_UC && k <= C_RX_BC) || k == C_RX_VLAN || k == C_RX_PAUSE) return "R4";
    return "R3";
  endfunction

  // expected-count model written from the requirements
  task automatic model_ev(bit tx, int len, bit fcs, bit aln, bit lbad, bit drp,
                          bit pau, bit vl, int dst);
    int edges[7] = '{64, 127, 255, 511, 1023, 1518, 65535};
    bit sh, lg;
    if (tx) begin
      exp_c[C_TX_OCT] += 64'(len);
      if (fcs) exp_c[C_TX_ERR]++;
      else begin
        exp_c[C_TX_GOOD]++;
        if (vl)  exp_c[C_TX_VLAN]++;
        if (pau) exp_c[C_TX_PAUSE]++;
        if (dst < 3) exp_c[C_TX_UC + dst]++;
      end
    end else if (drp) begin
      exp_c[C_RX_DROP]++;
    end else begin
      sh = (len < 64);
      lg = (len > model_max);
      exp_c[C_RX_OCT] += 64'(len);
      if (fcs)  exp_c[C_RX_FCS]++;
      if (aln)  exp_c[C_RX_ALIGN]++;
      if (lbad) exp_c[C_RX_INRANGE]++;
      if (lg)   exp_c[C_RX_LONG]++;
      if (fcs || aln || lbad || sh || lg) exp_c[C_RX_ERR]++;
      else begin
        exp_c[C_RX_GOOD]++;
        if (vl)  exp_c[C_RX_VLAN]++;
        if (pau) exp_c[C_RX_PAUSE]++;
        if (dst < 3) exp_c[C_RX_UC + dst]++;
      end
      if (sh)      exp_c[fcs ? C_RX_FRAG : C_RX_UNDER]++;
      else if (lg) exp_c[fcs ? C_RX_JAB : C_RX_OVER]++;
      else begin
        for (int b = 0; b < 7; b++)
          if (len <= edges[b]) begin exp_c[C_RX_B64 + b]++; break; end
      end
    end
  endtask

  // drive one event in the current cycle (caller is at a falling edge)
  task automatic put_ev(bit tx, int len, bit fcs, bit aln, bit lbad, bit drp,
                        bit pau, bit vl, int dst);
    ev_valid = 1; ev_tx = tx; ev_len = 16'(len); ev_fcs_bad = fcs;
    ev_align_bad = aln; ev_len_bad = lbad; ev_drop = drp; ev_pause = pau;
    ev_vlan = vl; ev_dst = 2'(dst);
    model_ev(tx, len, fcs, aln, lbad, drp, pau, vl, dst);
  endtask

  task automatic send(bit tx, int len, bit fcs, bit aln, bit lbad, bit drp,
                      bit pau, bit vl, int dst);
    @(negedge clk);
    put_ev(tx, len, fcs, aln, lbad, drp, pau, vl, dst);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      ev_valid = 0; rd_en = 0; maxlen_we = 0;
    end
  endtask

  task automatic read_word(int a, output logic [31:0] d);
    @(negedge clk);
    ev_valid = 0; rd_en = 1; rd_addr = 6'(a);
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic set_max(int v);
    idle(3);
    @(negedge clk);
    maxlen_we = 1; maxlen_wdata = 16'(v);
    @(negedge clk);
    maxlen_we = 0;
    model_max = v;
  endtask

  task automatic check_all(string what);
    logic [31:0] hi, lo;
    idle(3);
    for (int k = 0; k < NUM_CTR; k++) begin
      read_word(2 * k, hi);
      read_word(2 * k + 1, lo);
      chk(req_of(k), $sformatf("%s ctr%0d", what, k), {hi, lo}, exp_c[k]);
    end
  endtask

  task automatic random_burst(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if ($urandom_range(0, 9) < 8)
        put_ev($urandom_range(0, 1), $urandom_range(20, 2100), $urandom_range(0, 5) == 0,
               $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
               $urandom_range(0, 11) == 0, $urandom_range(0, 7) == 0,
               $urandom_range(0, 3) == 0, $urandom_range(0, 3));
      else ev_valid = 0;
      rd_en = $urandom_range(0, 1);
      rd_addr = 6'($urandom_range(0, 63));
    end
    idle(1);
  endtask

  initial begin
    logic [31:0] w, w2, snap;
    void'($urandom(32'd4242));
    for (int k = 0; k < NUM_CTR; k++) exp_c[k] = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R1", "rd_data after reset", 64'(rd_data), 64'd0);
    check_all("R1 reset");

    // directed received frames at the default limit of 1536
    send(0, 40, 0, 0, 0, 0, 0, 0, 0);   // undersize
    send(0, 40, 1, 0, 0, 0, 0, 0, 0);   // fragment
    send(0, 64, 0, 0, 0, 0, 0, 1, 0);
    send(0, 65, 0, 0, 0, 0, 1, 0, 1);
    send(0, 127, 0, 0, 0, 0, 0, 0, 2);
    send(0, 128, 0, 0, 0, 0, 0, 0, 3);
    send(0, 255, 0, 0, 0, 0, 0, 0, 0);
    send(0, 256, 0, 0, 0, 0, 0, 0, 1);
    send(0, 511, 0, 0, 0, 0, 0, 0, 0);
    send(0, 512, 0, 0, 0, 0, 0, 0, 0);
    send(0, 1023, 0, 0, 0, 0, 0, 0, 2);
    send(0, 1024, 0, 0, 0, 0, 0, 0, 0);
    send(0, 1518, 0, 0, 0, 0, 0, 0, 0);
    send(0, 1519, 0, 0, 0, 0, 0, 0, 0);
    send(0, 1536, 0, 0, 0, 0, 0, 0, 0); // top of last bin
    send(0, 1537, 0, 0, 0, 0, 0, 0, 0); // oversize
    send(0, 1600, 1, 0, 0, 0, 0, 0, 0); // jabber
    send(0, 100, 0, 1, 0, 0, 0, 0, 0);  // alignment
    send(0, 200, 0, 0, 1, 0, 0, 0, 0);  // in-range length error
    send(0, 300, 1, 0, 0, 1, 1, 1, 0);  // dropped: only the drop counter
    check_all("R3 rx directed");

    // programmable limit
    set_max(2000);
    send(0, 1600, 0, 0, 0, 0, 0, 0, 0);
    send(0, 2000, 0, 0, 0, 0, 0, 0, 0);
    send(0, 2001, 0, 0, 0, 0, 0, 0, 0);
    set_max(200);
    send(0, 150, 0, 0, 0, 0, 0, 0, 0);
    send(0, 300, 0, 0, 0, 0, 0, 0, 0);
    send(0, 300, 1, 0, 0, 0, 0, 0, 0);
    idle(3);
    read_word(2 * C_RX_OVER, w); read_word(2 * C_RX_OVER + 1, w2);
    chk("R8", "oversize after limit changes", {w, w2}, exp_c[C_RX_OVER]);
    read_word(2 * C_RX_BMAX, w); read_word(2 * C_RX_BMAX + 1, w2);
    chk("R8", "top bin after limit changes", {w, w2}, exp_c[C_RX_BMAX]);
    check_all("R8 limit");
    set_max(1536);

    // transmitted frames; rx-only flags must be ignored
    send(1, 64, 0, 0, 0, 0, 1, 1, 0);
    send(1, 900, 1, 0, 0, 0, 0, 0, 1);
    send(1, 300, 0, 1, 1, 1, 0, 0, 2);
    send(1, 20, 0, 0, 0, 0, 0, 0, 1);
    check_all("R9 tx directed");

    // shadow capture of the lower word
    idle(3);
    read_word(2 * C_RX_OCT, w);
    snap = exp_c[C_RX_OCT][31:0];
    send(0, 100, 0, 0, 0, 0, 0, 0, 0);
    send(0, 100, 0, 0, 0, 0, 0, 0, 0);
    send(0, 100, 0, 0, 0, 0, 0, 0, 0);
    idle(3);
    read_word(2 * C_RX_OCT + 1, w2);
    chk("R11", "lower word returns capture", 64'(w2), 64'(snap));
    read_word(2 * C_RX_OCT + 1, w2);
    chk("R11", "second lower read is live", 64'(w2), 64'(exp_c[C_RX_OCT][31:0]));
    read_word(2 * C_RX_OCT, w);
    read_word(2 * C_TX_OCT + 1, w2);
    chk("R11", "other counter lower is live", 64'(w2), 64'(exp_c[C_TX_OCT][31:0]));

    // read data holds while idle
    idle(5);
    chk("R2", "rd_data holds", 64'(rd_data), 64'(w2));

    // random traffic with concurrent reads
    random_burst(1500);
    check_all("R12 random");

    // back-to-back maximum-length tx frames carrying into the upper word
    for (int c = 0; c < 65600; c++) begin
      @(negedge clk);
      put_ev(1, 65535, 0, 0, 0, 0, 0, 0, 0);
      rd_en = $urandom_range(0, 1);
      rd_addr = 6'($urandom_range(0, 63));
    end
    idle(1);
    check_all("R12 carry");
    read_word(2 * C_TX_OCT, w);
    chk("R12", "tx octet upper word", 64'(w), 64'(exp_c[C_TX_OCT][63:32]));

    done = 1;
    summary();
    $finish;
  end

endmodule